// File: doc/BRIEF.md
# Timer-Shared Parallel I/O Port

This block is a parallel I/O port whose pins are shared with a timer. Software reaches it over a small word-wide register bus. The bus exposes three registers: a data latch, a per-pin direction mask, and a status word that reports two dedicated auxiliary inputs. Each capture/compare pin can be owned by the timer's output-compare logic. While compare owns the pin, the timer's value goes to the pad and software writes wait in the latch. When compare releases the pin, the latch value reaches the pad.

Reads of the data register always return the synchronized level seen at the pads, never the latch. The same synchronized levels go to the timer's capture edge detectors. On capture/compare pins that are configured as inputs, a software write to the data register is presented to the capture path as a pin level. A write therefore produces a capture edge exactly when it differs from the level the capture logic last saw. Parameters set which pins are capture/compare, output-only or input-only.

Top module: `timer_gpio_port`

## Requirements
- R1: After reset the direction and data registers are zero, every `pad_oe` and `pad_out` bit is 0 and every `cap_level` bit is 0.
- R2: Bus address 1 holds the direction mask, where 1 means output. Bits of input-only pins (not in `CC_MASK` or `OUT_MASK`; pins 7:6 by default) read back 0 and never set `pad_oe`. `pad_oe` follows a direction write one cycle after the write edge.
- R3: A write to bus address 0 stores bits W-1:0 in the data latch. For an output pin not owned by compare, `pad_out` shows the latch value one cycle after the write edge.
- R4: On a capture/compare pin (`CC_MASK`, pins 3:0 by default) with `oc_en` set, `pad_out` follows `oc_val` one cycle later. Data writes do not change `pad_out` on that pin.
- R5: When `oc_en` is cleared on a capture/compare pin, `pad_out` returns to the last value written to the latch one cycle later.
- R6: A read of address 0 returns the synchronized pad level in bits W-1:0, not the latch contents. This holds for input and output pins alike.
- R7: A pad change is seen by a read whose request is issued two or more cycles after the change. A read issued in the cycle right after the change still returns the old level.
- R8: `cap_level` follows each pin's synchronized level and changes on the third clock edge after a pad change.
- R9: A data write on a capture/compare pin whose direction bit is 0 sets that pin's `cap_level` to the written bit at the write edge. The value then holds until the synchronized pin level next changes. Pins that are not capture/compare take no such injection.
- R10: A read of address 2 returns the synchronized `acc_in` in bit 0 and the synchronized `tclk_in` in bit 1, with all other bits 0.
- R11: `oc_en` and `oc_val` have no effect on pins outside `CC_MASK`. `oc_en` does not enable the pad driver on a pin whose direction bit is 0.
- R12: `bus_rvalid` is high for exactly the cycle after a read request, with `bus_rdata` registered. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read request |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 status |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| oc_en | input | W | Output compare owns the pin |
| oc_val | input | W | Output compare drive value |
| cap_level | output | W | Pin level toward the capture edge detectors |
| pad_in | input | W | Level sensed at the pads |
| pad_oe | output | W | Pad driver enable |
| pad_out | output | W | Pad drive value |
| acc_in | input | 1 | Pulse-accumulator input pin |
| tclk_in | input | 1 | External timer clock input pin |

## Verification
Pad enable and drive values are due one clock edge after the write edge or the `oc_en`/`oc_val` change that causes them. The bench samples them at the following falling edge. A capture injection is due at the write edge itself, and a pad change reaches `cap_level` on the third edge. The bench samples just before and just after that edge to pin down the latency. Readback passes through two synchronizer flops and a registered read port. The bench issues read requests at measured distances from each stimulus, including one cycle too early for a pad change. For a driven output pin it waits out the full loop from latch to pad to synchronizer before reading.

// File: rtl/tgp_pkg.sv
package tgp_pkg;
  localparam int ADDR_W = 2;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t A_DATA = 2'd0;
  localparam addr_t A_DIR  = 2'd1;
  localparam addr_t A_STAT = 2'd2;
  localparam int    AUX_N  = 2;
endpackage

// File: rtl/tgp_sync.sv
module tgp_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/tgp_regs.sv
module tgp_regs
  import tgp_pkg::*;
#(
  parameter int           W       = 8,
  parameter int           DW      = 16,
  parameter logic [W-1:0] WR_MASK = 8'h3F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  addr_t            bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [W-1:0]     pin_lvl,
  input  logic [AUX_N-1:0] aux_lvl,
  output logic [W-1:0]     latch_q,
  output logic [W-1:0]     dir_q,
  output logic             data_wr,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid
);
  logic [DW-1:0] rd_nx;
  logic          unused_hi;

  assign unused_hi = ^bus_wdata[DW-1:W];
  assign data_wr   = bus_we && (bus_addr == A_DATA);

  always_comb begin
    rd_nx = '0;
    case (bus_addr)
      A_DATA:  rd_nx[W-1:0]     = pin_lvl;
      A_DIR:   rd_nx[W-1:0]     = dir_q;
      A_STAT:  rd_nx[AUX_N-1:0] = aux_lvl;
      default: rd_nx            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '0;
      dir_q      <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (data_wr)
        latch_q <= bus_wdata[W-1:0];
      if (bus_we && (bus_addr == A_DIR))
        dir_q <= bus_wdata[W-1:0] & WR_MASK;
      bus_rvalid <= bus_re;
      if (bus_re)
        bus_rdata <= rd_nx;
    end
  end

  assert_rvalid_R12: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid);
  assert_rvalid_drop_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> !bus_rvalid);
  assert_unmapped_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (bus_addr > A_STAT)) |=> (bus_rdata == '0));
  assert_data_latch_R3: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (latch_q == $past(bus_wdata[W-1:0])));
endmodule

// File: rtl/tgp_pin_mux.sv
module tgp_pin_mux #(
  parameter int           W       = 8,
  parameter logic [W-1:0] CC_MASK = 8'h0F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] oc_en,
  input  logic [W-1:0] oc_val,
  input  logic [W-1:0] pin_lvl,
  input  logic         data_wr,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] cap_level
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic drv;
    logic inj;
    logic oe_b;
    logic out_b;
    logic cap_b;
    logic lvl_d;

    if (CC_MASK[i]) begin : g_cc
      assign drv = oc_en[i] ? oc_val[i] : latch[i];
      assign inj = data_wr && !dir[i];

      assert_oc_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(oc_en[i])) |-> (out_b == $past(oc_val[i])));
      assert_release_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(oc_en[i])) |-> (out_b == $past(latch[i])));
      assert_inject_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(inj)) |-> (cap_b == $past(wbits[i])));
    end else begin : g_fix
      logic unused_oc;
      assign unused_oc = oc_en[i] ^ oc_val[i];
      assign drv = latch[i];
      assign inj = 1'b0;

      assert_fixed_drive_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_b == $past(latch[i])));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        oe_b  <= 1'b0;
        out_b <= 1'b0;
        cap_b <= 1'b0;
        lvl_d <= 1'b0;
      end else begin
        oe_b  <= dir[i];
        out_b <= drv;
        lvl_d <= pin_lvl[i];
        if (inj)
          cap_b <= wbits[i];
        else if (pin_lvl[i] != lvl_d)
          cap_b <= pin_lvl[i];
      end
    end

    assign pad_oe[i]    = oe_b;
    assign pad_out[i]   = out_b;
    assign cap_level[i] = cap_b;

    assert_dir_oe_R11: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(dir[i])) |-> !oe_b);
  end
endmodule

// File: rtl/timer_gpio_port.sv
module timer_gpio_port
  import tgp_pkg::*;
#(
  parameter int           W        = 8,
  parameter int           DW       = 16,
  parameter logic [W-1:0] CC_MASK  = 8'h0F,
  parameter logic [W-1:0] OUT_MASK = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic [W-1:0]      oc_en,
  input  logic [W-1:0]      oc_val,
  output logic [W-1:0]      cap_level,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  input  logic              acc_in,
  input  logic              tclk_in
);
  localparam logic [W-1:0] WR_MASK = CC_MASK | OUT_MASK;
  localparam int           SYNC_N  = W + AUX_N;

  logic [SYNC_N-1:0] sync_q;
  logic [W-1:0]      pin_lvl;
  logic [AUX_N-1:0]  aux_lvl;
  logic [W-1:0]      latch_q;
  logic [W-1:0]      dir_q;
  logic              data_wr;

  tgp_sync #(.N(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tclk_in, acc_in, pad_in}),
    .q   (sync_q)
  );

  assign pin_lvl = sync_q[W-1:0];
  assign aux_lvl = sync_q[SYNC_N-1:W];

  tgp_regs #(.W(W), .DW(DW), .WR_MASK(WR_MASK)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pin_lvl    (pin_lvl),
    .aux_lvl    (aux_lvl),
    .latch_q    (latch_q),
    .dir_q      (dir_q),
    .data_wr    (data_wr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  tgp_pin_mux #(.W(W), .CC_MASK(CC_MASK)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .dir       (dir_q),
    .latch     (latch_q),
    .oc_en     (oc_en),
    .oc_val    (oc_val),
    .pin_lvl   (pin_lvl),
    .data_wr   (data_wr),
    .wbits     (bus_wdata[W-1:0]),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .cap_level (cap_level)
  );

  assert_inonly_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~WR_MASK) == '0);
endmodule

// File: tb/tb_timer_gpio_port.sv
module tb_timer_gpio_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  oc_en = '0;
  logic [7:0]  oc_val = '0;
  logic [7:0]  cap_level;
  logic [7:0]  pad_in;
  logic [7:0]  pad_oe;
  logic [7:0]  pad_out;
  logic        acc_in = 1'b0;
  logic        tclk_in = 1'b0;
  logic [7:0]  ext_lvl = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [15:0] rd_val;
  logic        rv_val;

  always #5 clk = ~clk;

  // pad model: a driven pin shows the driven value, otherwise the external level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

  timer_gpio_port dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .oc_en(oc_en), .oc_val(oc_val), .cap_level(cap_level), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .acc_in(acc_in), .tclk_in(tclk_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    rd_val = bus_rdata;
    rv_val = bus_rvalid;
  endtask

  initial begin
    wait_neg(4);
    rst = 1'b0;
    wait_neg(1);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 cap_level", cap_level, 8'h00);
    bus_read(2'd1);
    chk("R1 dir reset", rd_val, 16'h0);
    bus_read(2'd0);
    chk("R1 data reads pins", rd_val, 16'h0);

    // R2 direction sweep
    for (int d = 0; d < 256; d++) begin
      bus_write(2'd1, 16'(d));
      bus_read(2'd1);
      chk("R2 dir readback", rd_val, 32'(d & 8'h3F));
      chk("R2 pad_oe", pad_oe, 32'(d & 8'h3F));
    end

    // R3 / R6 data sweep on output pins
    ext_lvl = 8'h80;
    bus_write(2'd1, 16'h003F);
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd0, 16'(v));
      wait_neg(1);
      chk("R3 pad_out", 32'(pad_out & 8'h3F), 32'(v & 8'h3F));
      wait_neg(1);
      bus_read(2'd0);
      chk("R6 output readback", rd_val, 32'((v & 8'h3F) | 8'h80));
    end

    // R6 input sweep: readback is the pin, not the latch
    bus_write(2'd1, 16'h0000);
    bus_write(2'd0, 16'h00FF);
    wait_neg(1);
    chk("R2 inputs not driven", pad_oe, 8'h00);
    for (int e = 0; e < 256; e++) begin
      ext_lvl = 8'(e);
      wait_neg(1);
      bus_read(2'd0);
      chk("R6 input readback", rd_val, 32'(e));
    end

    // R7 latency of readback
    ext_lvl = 8'h00;
    wait_neg(3);
    ext_lvl = 8'hFF;
    bus_read(2'd0);
    chk("R7 early read old", rd_val, 16'h0000);
    bus_read(2'd0);
    chk("R7 later read new", rd_val, 16'h00FF);

    // R8 capture level timing
    ext_lvl = 8'h00;
    wait_neg(4);
    chk("R8 cap settled", cap_level, 8'h00);
    ext_lvl = 8'hA5;
    wait_neg(2);
    chk("R8 cap before third edge", cap_level, 8'h00);
    wait_neg(1);
    chk("R8 cap at third edge", cap_level, 8'hA5);

    // R9 write injection into capture path
    ext_lvl = 8'h00;
    wait_neg(4);
    bus_write(2'd0, 16'h00FF);
    chk("R9 inject cc pins only", cap_level, 8'h0F);
    wait_neg(3);
    chk("R9 injected level holds", cap_level, 8'h0F);
    bus_write(2'd0, 16'h0000);
    chk("R9 inject falling", cap_level, 8'h00);
    bus_write(2'd0, 16'h0005);
    chk("R9 inject pattern", cap_level, 8'h05);
    ext_lvl = 8'h0A;
    wait_neg(3);
    chk("R9 pin change after inject", cap_level, 8'h0F);

    // R4 compare ownership
    ext_lvl = 8'h00;
    bus_write(2'd1, 16'h003F);
    bus_write(2'd0, 16'h0005);
    oc_val = 8'h0A; oc_en = 8'h0F;
    wait_neg(1);
    chk("R4 compare drives", 32'(pad_out & 8'h3F), 32'h0A);
    bus_write(2'd0, 16'h0033);
    wait_neg(1);
    chk("R4 write held back", 32'(pad_out & 8'h3F), 32'h3A);
    for (int k = 0; k < 16; k++) begin
      oc_val = 8'(k);
      wait_neg(1);
      chk("R4 oc_val sweep", 32'(pad_out & 8'h0F), 32'(k));
    end

    // R5 release
    oc_en = 8'h00;
    wait_neg(1);
    chk("R5 release to latch", 32'(pad_out & 8'h3F), 32'h33);
    oc_en = 8'h05; oc_val = 8'h00;
    wait_neg(1);
    chk("R5 partial ownership", 32'(pad_out & 8'h3F), 32'h32);

    // R11 compare ignored off cc pins and on input pins
    oc_en = 8'hFF; oc_val = 8'h00;
    wait_neg(1);
    chk("R11 non-cc ignores compare", 32'(pad_out & 8'h30), 32'h30);
    bus_write(2'd1, 16'h0000);
    wait_neg(1);
    chk("R11 compare no oe", pad_oe, 8'h00);
    oc_en = 8'h00;

    // R10 status inputs
    for (int s = 0; s < 4; s++) begin
      acc_in = s[0]; tclk_in = s[1];
      wait_neg(1);
      bus_read(2'd2);
      chk("R10 status", rd_val, 32'(s));
    end

    // R12 unmapped read and rvalid
    bus_read(2'd3);
    chk("R12 unmapped zero", rd_val, 16'h0000);
    chk("R12 rvalid high", 32'(rv_val), 32'h1);
    wait_neg(1);
    chk("R12 rvalid drops", 32'(bus_rvalid), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule